// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives a clause-22 management interface toward an Ethernet PHY from a small register file. Software writes one 32-bit word that already holds the start code, opcode, PHY address, register address, turnaround pattern and, for writes, the data. The block sends 32 preamble ones followed by that word, MSB first, on the serial data line. It generates the management clock from the system clock using a programmed divider.

For a read (opcode bits 29:28 = `10`), the block releases the data line from the second turnaround bit to the end of the frame. It samples the 16 returned bits and places them in bits 15:0 of the frame register. If no PHY drives the line, it floats high and the read returns 0xFFFF.

At the end of every frame the block sets a sticky completion event. Software clears the event by writing 1 to it. The event raises the interrupt output only when the matching mask bit is set. With the mask at zero, software polls the event register.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero, `mdc_o` is low, `mdio_oe_o` is low and `irq_o` is low.
- R2: A frame sends 32 ones and then frame-register bits 31 down to 0. Each bit is driven for one full MDC period. The data line changes only while MDC is low and holds steady while MDC is high.
- R3: The divider sits in speed-register bits DIV_W:1 and reads back in those same bits. One MDC period lasts 4 × divider system clocks.
- R4: While the divider is 0, a frame-register write loads the register but starts no frame. MDC stays low and no completion event is raised.
- R5: For a read opcode (bits 29:28 = `10`), `mdio_oe_o` is low from bit 47 of the 64-bit frame (the second turnaround bit) through bit 63. The 16 bits sampled on the MDC rising edges of frame bits 48..63 replace frame-register bits 15:0, MSB first. Bits 31:16 of the register are kept.
- R6: A read with the line left high by every device returns 0xFFFF in frame-register bits 15:0.
- R7: Completion sets event-register bit 23 at the end of the frame, and the bit stays set until software clears it. Writing a word with bit 23 set to the event register clears it. Writing a word with bit 23 clear leaves it unchanged.
- R8: `irq_o` is high exactly when event bit 23 and mask-register bit 23 are both set.
- R9: A frame-register write while a frame is in progress is ignored. The register keeps its value and the frame already on the line continues unchanged.
- R10: After a write frame (opcode `01`) completes, the frame register still holds the word that was sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 frame, 1 event, 2 mask, 3 speed |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Completion interrupt |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe_o | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench builds the block with DIV_W = 4. With that width, a write of all ones to the speed register lands the whole divider field at a known readback value, which exercises the field position. Frames run with dividers 1, 2 and 3, so each frame takes at most a few hundred clocks. That leaves room for writes, reads with and without a responding PHY, a write attempted mid-frame, and the zero-divider case. A PHY model in the bench drives the read data on MDC falling edges, and a scoreboard compares each complete 64-bit frame and its enable pattern against the queued command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_SPEED = 2'd3
  } reg_sel_e;

  localparam int unsigned EV_BIT    = 23;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FRAME_LEN = PRE_LEN + WORD_W;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned RD_W      = 16;
  localparam logic [1:0]  OP_READ   = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          mdc_q;
  logic          wrap;

  // half period = 2 * div clocks
  assign lim  = {div_i, 1'b0} - {{DIV_W{1'b0}}, 1'b1};
  assign wrap = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + {{DIV_W{1'b0}}, 1'b1};
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic              is_rd_o,
  output logic [RD_W-1:0]   rd_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_LEN + 15);
  localparam logic [IDX_W-1:0] CAP_IDX  = IDX_W'(PRE_LEN + 16);

  logic              busy_q;
  logic              rd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;
  logic [RD_W-1:0]   cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      cap_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= (word_i[29:28] == OP_READ);
      idx_q  <= '0;
      word_q <= word_i;
      cap_q  <= '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && idx_q >= CAP_IDX)
        cap_q <= {cap_q[RD_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
        else idx_q <= idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
      end
    end
  end

  // upper index bit selects word vs preamble; low bits pick MSB first
  assign mdo_o     = busy_q && (idx_q[IDX_W-1] ? word_q[~idx_q[IDX_W-2:0]] : 1'b1);
  assign oe_o      = busy_q && !(rd_q && idx_q >= REL_IDX);
  assign done_o    = busy_q && fall_i && (idx_q == LAST_IDX);
  assign busy_o    = busy_q;
  assign is_rd_o   = rd_q;
  assign rd_data_o = cap_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  reg_sel_e          sel;
  logic [31:0]       frame_q;
  logic              ev_q;
  logic              mask_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy;
  logic              done;
  logic              is_rd;
  logic [RD_W-1:0]   rd_data;
  logic              rise;
  logic              fall;
  logic              frame_wr;
  logic              start;

  assign sel      = reg_sel_e'(reg_addr_i);
  assign frame_wr = reg_we_i && (sel == SEL_FRAME) && !busy;
  assign start    = frame_wr && (div_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      ev_q    <= 1'b0;
      mask_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      if (frame_wr) frame_q <= reg_wdata_i;
      else if (done && is_rd) frame_q[RD_W-1:0] <= rd_data;

      if (done) ev_q <= 1'b1;
      else if (reg_we_i && sel == SEL_EVENT && reg_wdata_i[EV_BIT]) ev_q <= 1'b0;

      if (reg_we_i && sel == SEL_MASK) mask_q <= reg_wdata_i[EV_BIT];
      if (reg_we_i && sel == SEL_SPEED) div_q <= reg_wdata_i[DIV_W:1];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_FRAME: reg_rdata_o = frame_q;
      SEL_EVENT: reg_rdata_o[EV_BIT] = ev_q;
      SEL_MASK:  reg_rdata_o[EV_BIT] = mask_q;
      SEL_SPEED: reg_rdata_o = {{(31-DIV_W){1'b0}}, div_q, 1'b0};
    endcase
  end

  assign irq_o = ev_q & mask_q;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter u_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .word_i    (reg_wdata_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdo_o     (mdio_o),
    .oe_o      (mdio_oe_o),
    .done_o    (done),
    .is_rd_o   (is_rd),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned DIV_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mdc_i,
  input logic             mdo_i,
  input logic             oe_i,
  input logic             busy_i,
  input logic             ev_i,
  input logic [31:0]      frame_i,
  input logic [DIV_W-1:0] div_i
);
  // R2
  mdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_i && $past(mdc_i) |-> $stable(mdo_i));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i && !oe_i);

  // R4
  no_div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && div_i == '0 |=> !busy_i);

  // R7
  ev_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_i) |-> $fell(busy_i));

  // R9
  frame_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(frame_i));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mdc_i   (mdc_o),
  .mdo_i   (mdio_o),
  .oe_i    (mdio_oe_o),
  .busy_i  (busy),
  .ev_i    (ev_q),
  .frame_i (frame_q),
  .div_i   (div_q)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int unsigned DIV_W = 4;
  localparam logic [1:0] A_FRAME = 2'd0, A_EVENT = 2'd1, A_MASK = 2'd2, A_SPEED = 2'd3;
  localparam logic [31:0] EVB = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, mdc, mdo, oe, mdi;
  logic        phy_bit = 1'b1;

  int total = 0;
  int bad = 0;
  int rise_n = 0;
  int rise_total = 0;
  int cur_div = 1;
  logic cur_rd = 1'b0;
  logic phy_present = 1'b0;
  logic [15:0] phy_data = '0;
  logic [63:0] bits, oes;
  time t0;

  typedef struct {
    logic [31:0] word;
    logic        rd;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  assign mdi = oe ? mdo : phy_bit;

  mdio_master #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdi)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge mdc) begin
    bits[63-rise_n] = mdo;
    oes[63-rise_n]  = oe;
    if (rise_n == 0) t0 = $time;
    if (rise_n == 1) chk(($time - t0) == time'(40 * cur_div), "R3 mdc period",
                         64'($time - t0), 64'(40 * cur_div));
    rise_n++;
    rise_total++;
    if (rise_n == 64) begin
      rise_n = 0;
      if (expq.size() == 0) chk(1'b0, "R2 unexpected frame", bits, 64'd0);
      else begin
        exp_t e;
        logic [63:0] eb, eo, m;
        e  = expq.pop_front();
        eb = {32'hFFFF_FFFF, e.word};
        eo = e.rd ? {47'h7FFF_FFFF_FFFF, 17'd0} : {64{1'b1}};
        m  = e.rd ? {47'h7FFF_FFFF_FFFF, 17'd0} : {64{1'b1}};
        chk((bits & m) == (eb & m), "R2 serial frame", bits & m, eb & m);
        chk(oes == eo, "R5 output enable pattern", oes, eo);
      end
    end
  end

  // PHY model: drives data after the falling edge that precedes each sampled bit
  always @(negedge mdc) begin
    if (cur_rd && phy_present && rise_n >= 48 && rise_n < 64) phy_bit <= phy_data[63-rise_n];
    else phy_bit <= 1'b1;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      rd(A_EVENT, d);
      if (d[23]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic frame(input logic [31:0] w, input logic is_rd, input logic present,
                       input logic [15:0] pd, input string req);
    logic [31:0] d, expw;
    bit ok;
    expq.push_back('{word: w, rd: is_rd});
    cur_rd = is_rd; phy_present = present; phy_data = pd;
    wr(A_FRAME, w);
    wait_done(ok);
    chk(ok, "R7 event set", 64'(ok), 64'd1);
    expw = is_rd ? {w[31:16], (present ? pd : 16'hFFFF)} : w;
    rd(A_FRAME, d);
    chk(d == expw, req, 64'(d), 64'(expw));
    chk(expq.size() == 0, "R2 frame consumed", 64'(expq.size()), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mdc == 1'b0 && oe == 1'b0 && irq == 1'b0, "R1 outputs", {mdc, oe, irq}, 64'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 32'd0, "R1 register zero", 64'(d), 64'd0);
    end
    rst_n = 1'b1;

    // R4 divider zero: register loads, nothing starts
    r0 = rise_total;
    wr(A_FRAME, 32'h5082_1234);
    repeat (200) @(negedge clk);
    chk(rise_total == r0, "R4 no mdc", 64'(rise_total), 64'(r0));
    rd(A_EVENT, d);
    chk(d == 32'd0, "R4 no event", 64'(d), 64'd0);
    rd(A_FRAME, d);
    chk(d == 32'h5082_1234, "R4 frame loaded", 64'(d), 64'h5082_1234);

    // R3 divider field position and width
    wr(A_SPEED, 32'hFFFF_FFFF);
    rd(A_SPEED, d);
    chk(d == 32'h0000_001E, "R3 speed readback", 64'(d), 64'h1E);

    // R10 write frame, divider 1
    wr(A_SPEED, 32'd2); cur_div = 1;
    frame(32'h5002_0000 | (32'd5 << 23) | (32'd4 << 18) | 32'hA5C3, 1'b0, 1'b1, 16'h0, "R10 write word kept");
    // R7 clear with bit clear: stays; with bit set: cleared
    wr(A_EVENT, ~EVB);
    rd(A_EVENT, d);
    chk(d[23] == 1'b1, "R7 w0 no clear", 64'(d), 64'(EVB));
    wr(A_EVENT, EVB);
    rd(A_EVENT, d);
    chk(d == 32'd0, "R7 w1 clears", 64'(d), 64'd0);

    // R5 read with PHY present, divider 2
    wr(A_SPEED, 32'd4); cur_div = 2;
    frame(32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18), 1'b1, 1'b1, 16'hC35A, "R5 read capture");
    wr(A_EVENT, 32'hFFFF_FFFF);
    frame(32'h6002_0000 | (32'd31 << 23) | (32'd31 << 18), 1'b1, 1'b1, 16'h8001, "R5 read capture edge bits");

    // R8 interrupt mask
    wr(A_MASK, EVB);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq with mask", 64'(irq), 64'd1);
    wr(A_MASK, 32'd0);
    @(negedge clk);
    chk(irq == 1'b0, "R8 masked", 64'(irq), 64'd0);
    wr(A_MASK, EVB);
    wr(A_EVENT, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(irq == 1'b0, "R8 cleared", 64'(irq), 64'd0);

    // R6 read with no PHY, divider 3
    wr(A_SPEED, 32'd6); cur_div = 3;
    frame(32'h6002_0000 | (32'd17 << 23) | (32'd1 << 18), 1'b1, 1'b0, 16'h0, "R6 absent phy 0xFFFF");
    chk(irq == 1'b1, "R8 irq after frame", 64'(irq), 64'd1);
    wr(A_EVENT, EVB);

    // R9 mid-frame write ignored
    wr(A_SPEED, 32'd2); cur_div = 1;
    expq.push_back('{word: 32'h5002_0000 | 32'h1111, rd: 1'b0});
    cur_rd = 1'b0;
    wr(A_FRAME, 32'h5002_0000 | 32'h1111);
    repeat (20) @(negedge clk);
    wr(A_FRAME, 32'h5002_0000 | 32'h2222);
    wait_done(ok);
    chk(ok, "R9 frame finished", 64'(ok), 64'd1);
    rd(A_FRAME, d);
    chk(d == 32'h5002_1111, "R9 busy write ignored", 64'(d), 64'h5002_1111);
    chk(expq.size() == 0, "R9 single frame", 64'(expq.size()), 64'd0);
    repeat (20) @(negedge clk);
    chk(rise_n == 0, "R9 no second frame", 64'(rise_n), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule